// File: doc/BRIEF.md
# CAN Basic-Mode Message Buffer

This block holds the message buffers of a CAN controller that runs without its message memory. A single transmit register set and a single receive register set take the place of the object store. The host fills the transmit set and raises a request flag. The block keeps that set frozen while the request is outstanding and hands it to the protocol engine's shift register as soon as the engine reports the bus idle. After lost arbitration or a bus error it re-arms the request by itself, and it drops the request when the frame completes or when the host withdraws it.

On the receive side every completed frame is copied from the engine's shift register into the receive set, with no acceptance filtering. The host may also take a snapshot of the live shift register at any moment, so it can watch traffic while a frame is still in progress. The receive control word reports a new-data flag, a message-lost flag and the received length. Its other bits read as zero.

One mode bit turns the buffering on. A separate 2-bit field selects what drives the transmit pin, which is useful for physical-layer tests while the mode is off.

Top module: `can_basic_buf`

## Requirements
- R1: On reset, `tx_busy`, `eng_load`, all buffer fields and both receive flags are zero.
- R2: With `basic_en` high and `tx_busy` low, a `hw_tx_req_set` pulse sets `tx_busy` at the next edge. `tx_busy` stays high until R5, R6 or R11 clears it.
- R3: A `hw_tx_we` pulse loads `tx_id`, `tx_dlc` and `tx_data` only while `tx_busy` is low. While `tx_busy` is high the pulse leaves all three unchanged.
- R4: A request waits for transmission until a cycle with `eng_bus_idle` high. In the cycle after that, `eng_load` is high for exactly one cycle, with `tx_id`, `tx_dlc` and `tx_data` showing the contents to shift out. `eng_load` is never high in any other case.
- R5: `eng_tx_done` during a started transmission clears `tx_busy` at the next edge.
- R6: `eng_tx_fail` during a started transmission, with no done or clear in the same cycle, keeps `tx_busy` high and re-arms the request, so a new `eng_load` follows the next bus-idle cycle.
- R7: `hw_tx_req_clr` clears `tx_busy` at the next edge, both while waiting and while transmitting, and it has priority over bus-idle, done and fail. After an abort, a later `eng_tx_fail` or `eng_bus_idle` produces no `eng_load`.
- R8: `eng_rx_done` copies `eng_sh_id`, `eng_sh_dlc` and `eng_sh_data` into `rx_id`, `rx_dlc` and `rx_data`, whatever the identifier is.
- R9: `hw_rx_snap` copies the current shift-register values into the receive set at the same edge.
- R10: Every capture sets new-data. A capture made while new-data is already set also sets message-lost. Message-lost stays set until cleared. `hw_rx_clr_flags` clears both flags, except in a cycle that also captures, where the capture wins. `rx_ctrl` has new-data at bit 15, message-lost at bit 14 and the DLC in bits 3:0. Bits 13:4 are zero.
- R11: While `basic_en` is low, requests and captures are ignored and `tx_busy` is forced low at the next edge.
- R12: `can_tx` follows `pin_sel`: 0 selects `eng_tx_bit`, 1 selects `eng_sample_pt`, 2 drives constant 0 and 3 drives constant 1. `pin_sel` must be 0 whenever `basic_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| basic_en | input | 1 | Buffer mode enable |
| pin_sel | input | 2 | Transmit pin source select |
| hw_tx_we | input | 1 | Host write strobe for the transmit set |
| hw_tx_id | input | ID_W | Host identifier |
| hw_tx_dlc | input | 4 | Host length code |
| hw_tx_data | input | DATA_W | Host payload |
| hw_tx_req_set | input | 1 | Request transmission |
| hw_tx_req_clr | input | 1 | Withdraw request (abort) |
| hw_rx_snap | input | 1 | Capture live shift register |
| hw_rx_clr_flags | input | 1 | Clear new-data and message-lost |
| eng_bus_idle | input | 1 | Engine reports idle bus |
| eng_tx_done | input | 1 | Engine finished transmission |
| eng_tx_fail | input | 1 | Engine lost arbitration or hit an error |
| eng_rx_done | input | 1 | Engine received a frame |
| eng_sh_id | input | ID_W | Live shift-register identifier |
| eng_sh_dlc | input | 4 | Live shift-register length |
| eng_sh_data | input | DATA_W | Live shift-register payload |
| eng_tx_bit | input | 1 | Engine transmit bit |
| eng_sample_pt | input | 1 | Sample-point strobe |
| eng_load | output | 1 | Load shift register from transmit set |
| tx_busy | output | 1 | Transmit request pending |
| tx_id | output | ID_W | Transmit set identifier |
| tx_dlc | output | 4 | Transmit set length |
| tx_data | output | DATA_W | Transmit set payload |
| rx_id | output | ID_W | Receive set identifier |
| rx_dlc | output | 4 | Receive set length |
| rx_data | output | DATA_W | Receive set payload |
| rx_ctrl | output | 16 | Receive control word |
| can_tx | output | 1 | Transmit pin |

## Verification
The hardest situation to reach is a retry race. A failure re-arms a request, and then the next bus-idle cycle coincides with an abort, or a host write lands while the set is locked. Directed sequences walk through fail-then-reload and abort-then-fail in order. A long random phase follows, with independent low-probability pulses on idle, done, fail and clear, so that these events keep colliding in the same cycle while a reference model tracks the expected state.

// File: rtl/can_basic_buf.sv
module can_basic_buf #(
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              basic_en,
  input  logic [1:0]        pin_sel,
  input  logic              hw_tx_we,
  input  logic [ID_W-1:0]   hw_tx_id,
  input  logic [3:0]        hw_tx_dlc,
  input  logic [DATA_W-1:0] hw_tx_data,
  input  logic              hw_tx_req_set,
  input  logic              hw_tx_req_clr,
  input  logic              hw_rx_snap,
  input  logic              hw_rx_clr_flags,
  input  logic              eng_bus_idle,
  input  logic              eng_tx_done,
  input  logic              eng_tx_fail,
  input  logic              eng_rx_done,
  input  logic [ID_W-1:0]   eng_sh_id,
  input  logic [3:0]        eng_sh_dlc,
  input  logic [DATA_W-1:0] eng_sh_data,
  input  logic              eng_tx_bit,
  input  logic              eng_sample_pt,
  output logic              eng_load,
  output logic              tx_busy,
  output logic [ID_W-1:0]   tx_id,
  output logic [3:0]        tx_dlc,
  output logic [DATA_W-1:0] tx_data,
  output logic [ID_W-1:0]   rx_id,
  output logic [3:0]        rx_dlc,
  output logic [DATA_W-1:0] rx_data,
  output logic [CTRL_W-1:0] rx_ctrl,
  output logic              can_tx
);
  localparam int PAD_W = CTRL_W - 2 - 4;

  typedef enum logic [1:0] {TX_IDLE, TX_PEND, TX_ACTIVE} tx_st_t;

  tx_st_t tx_st;
  logic   rx_new, rx_lost, rx_cap;

  assign tx_busy = (tx_st != TX_IDLE);
  assign rx_cap  = basic_en && (eng_rx_done || hw_rx_snap);
  assign rx_ctrl = {rx_new, rx_lost, {PAD_W{1'b0}}, rx_dlc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st    <= TX_IDLE;
      eng_load <= 1'b0;
    end else begin
      eng_load <= 1'b0;
      if (!basic_en) begin
        tx_st <= TX_IDLE;
      end else begin
        case (tx_st)
          TX_IDLE:   if (hw_tx_req_set) tx_st <= TX_PEND;
          TX_PEND:
            if (hw_tx_req_clr) tx_st <= TX_IDLE;
            else if (eng_bus_idle) begin
              tx_st    <= TX_ACTIVE;
              eng_load <= 1'b1;
            end
          TX_ACTIVE:
            if (hw_tx_req_clr || eng_tx_done) tx_st <= TX_IDLE;
            else if (eng_tx_fail) tx_st <= TX_PEND;
          default:   tx_st <= TX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_id   <= '0;
      tx_dlc  <= '0;
      tx_data <= '0;
    end else if (hw_tx_we && !tx_busy) begin
      tx_id   <= hw_tx_id;
      tx_dlc  <= hw_tx_dlc;
      tx_data <= hw_tx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_id   <= '0;
      rx_dlc  <= '0;
      rx_data <= '0;
      rx_new  <= 1'b0;
      rx_lost <= 1'b0;
    end else if (rx_cap) begin
      rx_id   <= eng_sh_id;
      rx_dlc  <= eng_sh_dlc;
      rx_data <= eng_sh_data;
      rx_new  <= 1'b1;
      rx_lost <= rx_lost | rx_new;
    end else if (hw_rx_clr_flags) begin
      rx_new  <= 1'b0;
      rx_lost <= 1'b0;
    end
  end

  always_comb begin
    case (pin_sel)
      2'd0:    can_tx = eng_tx_bit;
      2'd1:    can_tx = eng_sample_pt;
      2'd2:    can_tx = 1'b0;
      default: can_tx = 1'b1;
    endcase
  end

  a_r3_tx_set_locked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(tx_id) && $stable(tx_dlc) && $stable(tx_data));

  a_r4_load_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |-> $past(eng_bus_idle) && $past(tx_busy));

  a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |=> !eng_load);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && eng_tx_done && !eng_load && tx_st == TX_ACTIVE) |=> !tx_busy);

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && hw_tx_req_clr) |=> !tx_busy && !eng_load);

  a_r10_newdat_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap |=> rx_ctrl[CTRL_W-1]);

  a_r10_lost_on_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cap && rx_ctrl[CTRL_W-1]) |=> rx_ctrl[CTRL_W-2]);

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !basic_en |=> !tx_busy);

  a_r12_no_override_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    basic_en |-> pin_sel == 2'd0);
endmodule

// File: tb/tb_can_basic_buf.sv
module tb_can_basic_buf;
  localparam int ID_W = 29;
  localparam int DW   = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic basic_en;
  logic [1:0] pin_sel;
  logic hw_tx_we, hw_tx_req_set, hw_tx_req_clr, hw_rx_snap, hw_rx_clr_flags;
  logic [ID_W-1:0] hw_tx_id, eng_sh_id;
  logic [3:0] hw_tx_dlc, eng_sh_dlc;
  logic [DW-1:0] hw_tx_data, eng_sh_data;
  logic eng_bus_idle, eng_tx_done, eng_tx_fail, eng_rx_done, eng_tx_bit, eng_sample_pt;
  logic eng_load, tx_busy, can_tx;
  logic [ID_W-1:0] tx_id, rx_id;
  logic [3:0] tx_dlc, rx_dlc;
  logic [DW-1:0] tx_data, rx_data;
  logic [15:0] rx_ctrl;

  int checks = 0;
  int fails  = 0;

  int m_st;
  bit m_load, m_new, m_lost;
  logic [ID_W-1:0] m_tid, m_rid;
  logic [3:0] m_tdlc, m_rdlc;
  logic [DW-1:0] m_tdata, m_rdata;

  always #5 clk = ~clk;

  can_basic_buf #(.ID_W(ID_W), .DATA_W(DW)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pin_exp(logic [1:0] sel, bit b, bit sp);
    return (sel == 0) ? b : (sel == 1) ? sp : (sel == 2) ? 1'b0 : 1'b1;
  endfunction

  task automatic quiet();
    hw_tx_we = 0; hw_tx_req_set = 0; hw_tx_req_clr = 0; hw_rx_snap = 0;
    hw_rx_clr_flags = 0; eng_bus_idle = 0; eng_tx_done = 0; eng_tx_fail = 0;
    eng_rx_done = 0;
  endtask

  task automatic model();
    bit cap;
    int nst;
    m_load = 0;
    nst = m_st;
    if (!basic_en) nst = 0;
    else if (m_st == 0) begin if (hw_tx_req_set) nst = 1; end
    else if (m_st == 1) begin
      if (hw_tx_req_clr) nst = 0;
      else if (eng_bus_idle) begin nst = 2; m_load = 1; end
    end else begin
      if (hw_tx_req_clr || eng_tx_done) nst = 0;
      else if (eng_tx_fail) nst = 1;
    end
    if (hw_tx_we && m_st == 0) begin m_tid = hw_tx_id; m_tdlc = hw_tx_dlc; m_tdata = hw_tx_data; end
    cap = basic_en && (eng_rx_done || hw_rx_snap);
    if (cap) begin
      m_rid = eng_sh_id; m_rdlc = eng_sh_dlc; m_rdata = eng_sh_data;
      m_lost = m_lost | m_new; m_new = 1;
    end else if (hw_rx_clr_flags) begin m_new = 0; m_lost = 0; end
    m_st = nst;
  endtask

  task automatic compare();
    chk("R2 busy", 64'(tx_busy), 64'(m_st != 0));
    chk("R4 load", 64'(eng_load), 64'(m_load));
    chk("R3 tx id", 64'(tx_id), 64'(m_tid));
    chk("R3 tx dlc", 64'(tx_dlc), 64'(m_tdlc));
    chk("R3 tx data", tx_data, m_tdata);
    chk("R8 rx id", 64'(rx_id), 64'(m_rid));
    chk("R9 rx data", rx_data, m_rdata);
    chk("R10 rx ctrl", 64'(rx_ctrl), 64'({m_new, m_lost, 10'b0, m_rdlc}));
    chk("R12 pin", 64'(can_tx), 64'(pin_exp(pin_sel, eng_tx_bit, eng_sample_pt)));
  endtask

  task automatic step();
    model();
    @(negedge clk);
    compare();
    quiet();
  endtask

  task automatic rand_shift();
    eng_sh_id = ID_W'($urandom); eng_sh_dlc = 4'($urandom);
    eng_sh_data = {$urandom, $urandom};
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; basic_en = 0; pin_sel = 0; quiet();
    hw_tx_id = '0; hw_tx_dlc = '0; hw_tx_data = '0;
    eng_sh_id = '0; eng_sh_dlc = '0; eng_sh_data = '0;
    eng_tx_bit = 0; eng_sample_pt = 0;
    m_st = 0; m_load = 0; m_new = 0; m_lost = 0;
    m_tid = '0; m_tdlc = '0; m_tdata = '0; m_rid = '0; m_rdlc = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset busy", 64'(tx_busy), 0);
    chk("R1 reset load", 64'(eng_load), 0);
    chk("R1 reset ctrl", 64'(rx_ctrl), 0);
    chk("R1 reset tx data", tx_data, 0);

    // R12: pin override with mode off
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 4; v++) begin
        pin_sel = 2'(s); eng_tx_bit = v[0]; eng_sample_pt = v[1];
        #1 chk("R12 pin source", 64'(can_tx), 64'(pin_exp(pin_sel, eng_tx_bit, eng_sample_pt)));
      end
    pin_sel = 0;

    // R11: mode off ignores requests and captures
    rand_shift(); hw_tx_req_set = 1; eng_rx_done = 1; hw_rx_snap = 1; step();
    chk("R11 no busy when off", 64'(tx_busy), 0);
    chk("R11 no capture when off", 64'(rx_ctrl[15]), 0);

    basic_en = 1;
    hw_tx_we = 1; hw_tx_id = 29'h1ABCDE; hw_tx_dlc = 4'd8; hw_tx_data = 64'h1122334455667788; step();
    hw_tx_req_set = 1; step();
    chk("R2 busy after set", 64'(tx_busy), 1);
    repeat (3) step();
    chk("R4 no load without idle", 64'(eng_load), 0);
    hw_tx_we = 1; hw_tx_id = 29'h5; hw_tx_dlc = 4'd1; hw_tx_data = 64'hDEAD; step();
    chk("R3 locked write ignored", tx_data, 64'h1122334455667788);
    eng_bus_idle = 1; step();
    chk("R4 load pulse", 64'(eng_load), 1);
    step();
    chk("R4 load one cycle", 64'(eng_load), 0);
    eng_tx_fail = 1; step();
    chk("R6 retry keeps busy", 64'(tx_busy), 1);
    eng_bus_idle = 1; step();
    chk("R6 reload after retry", 64'(eng_load), 1);
    eng_tx_done = 1; step();
    chk("R5 done clears busy", 64'(tx_busy), 0);

    hw_tx_req_set = 1; step();
    eng_bus_idle = 1; step();
    hw_tx_req_clr = 1; step();
    chk("R7 abort clears busy", 64'(tx_busy), 0);
    eng_tx_fail = 1; step();
    eng_bus_idle = 1; step();
    step();
    chk("R7 no retry after abort", 64'(eng_load), 0);
    hw_tx_req_set = 1; step();
    hw_tx_req_clr = 1; eng_bus_idle = 1; step();
    chk("R7 clear beats idle", 64'(eng_load), 0);

    rand_shift(); eng_sh_id = 29'h1FFFFFFF; eng_rx_done = 1; step();
    chk("R8 unfiltered capture", 64'(rx_id), 64'(29'h1FFFFFFF));
    rand_shift(); hw_rx_snap = 1; step();
    chk("R9 snapshot data", rx_data, eng_sh_data);
    chk("R10 lost on overwrite", 64'(rx_ctrl[14]), 1);
    hw_rx_clr_flags = 1; step();
    chk("R10 flags cleared", 64'(rx_ctrl[15:14]), 0);

    for (int i = 0; i < 6000; i++) begin
      basic_en = ($urandom % 40) != 0;
      pin_sel = basic_en ? 2'd0 : 2'($urandom);
      rand_shift();
      eng_tx_bit = 1'($urandom); eng_sample_pt = 1'($urandom);
      hw_tx_we = ($urandom % 3) == 0;
      hw_tx_id = ID_W'($urandom); hw_tx_dlc = 4'($urandom); hw_tx_data = {$urandom, $urandom};
      hw_tx_req_set = ($urandom % 6) == 0;
      hw_tx_req_clr = ($urandom % 20) == 0;
      eng_bus_idle = ($urandom % 3) == 0;
      eng_tx_done = ($urandom % 8) == 0;
      eng_tx_fail = ($urandom % 10) == 0;
      eng_rx_done = ($urandom % 9) == 0;
      hw_rx_snap = ($urandom % 18) == 0;
      hw_rx_clr_flags = ($urandom % 7) == 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule